// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

This block recovers an I2C bus when a target device has been left holding SDA low, for example after a transfer was cut short. On a start request it takes over both bus lines through open-drain drive-low outputs. It clocks SCL a configurable number of times, checking SDA before every pulse, and stops early once the target has let go. It then synthesizes a STOP condition and hands the pins back to the normal controller. The sequence is paced by a half-period prescaler in clock cycles. With a 200 MHz clock, a value of 1000 gives a 5 us half-period, which is the usual 100 kHz rate. The usual pulse count is 9.

The SCL and SDA pin levels each pass through a two-stage synchronizer before the sequencer looks at them. Every high phase of SCL is timed from the moment SCL is actually seen high. A target that stretches the clock therefore lengthens the pulse instead of shortening it. If SCL stays low for good, a watchdog ends the attempt after a fixed number of busy cycles (50 ms at 200 MHz by default). It releases the lines, zeroes the remaining pulse count and raises a timeout flag.

Control and status are plain level signals. `busy_o` is the self-clearing enable flag and also tells the pin multiplexer that this block owns the lines.

Top module: `i2c_bus_unstick`

## Requirements
- R1: After reset, and whenever the block is idle, both drive-low outputs are 0 (released) and `busy_o` is 0; after reset `timeout_o` and `pulses_left_o` are 0.
- R2: A `start_i` sampled high while idle latches `pulse_count_i` and `half_cycles_i`, sets `busy_o` from the next cycle and clears `timeout_o`; `busy_o` drops by itself when the sequence ends.
- R3: The sequence opens with SCL driven low and SDA released for H cycles (H = latched half period), followed by one SDA sample cycle; with at least one pulse, SCL is first released in busy cycle H+1 (counting the first busy cycle as 0).
- R4: Each pulse releases SCL and counts H cycles only once synchronized SCL reads high, then drives SCL low for H cycles; with a pin that follows the drive at once, a high phase lasts H+2 cycles.
- R5: Before every pulse SDA (synchronized) is sampled; pulsing ends when SDA reads high or the remaining count is 0, so the number of pulses is p = min(count, pulses until the target releases), and `pulses_left_o` never rises during a run.
- R6: The STOP is made by driving SDA low while SCL is low for H cycles, releasing SCL (H cycles after it reads high), then releasing SDA while SCL stays high for a final H cycles; the block never changes its SDA drive while driving SCL high-released, except that release.
- R7: A run that ends normally lasts exactly 4H + 3 + p(2H + 3) busy cycles and leaves `pulses_left_o` = count - p and `timeout_o` = 0.
- R8: If `busy_o` has been high for TIMEOUT_CYCLES cycles, the run is aborted: lines released, `busy_o` low, `pulses_left_o` = 0, `timeout_o` = 1 until the next accepted start.
- R9: `start_i` and changes of `pulse_count_i` or `half_cycles_i` while busy have no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a recovery run (taken only when idle) |
| pulse_count_i | input | CNT_W | Maximum number of SCL pulses |
| half_cycles_i | input | HALF_W | Half-period in clock cycles (0 is treated as 1) |
| scl_i | input | 1 | SCL pin level (asynchronous) |
| sda_i | input | 1 | SDA pin level (asynchronous) |
| scl_drive_low_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | Run in progress; block owns the pins |
| timeout_o | output | 1 | Last run was aborted by the watchdog |
| pulses_left_o | output | CNT_W | Pulses still unused by the current or last run |

## Verification
The bench sweeps pulse count against the pulse after which a modelled target lets SDA go, including a target that never lets go, a count of zero and the largest count. A sequencer that skipped the SDA check, or sampled it one pulse late, would show up as a wrong pulse total and run length. The bench watches the pin levels for a false START and for a missing STOP, which would catch an SDA drive changed while SCL is high. It holds SCL stuck low to make the watchdog fire, and pokes start and the configuration mid-run, where a design that re-latched them would change the run length.

// File: rtl/i2c_unstick_pkg.sv
package i2c_unstick_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SAMPLE,
    ST_HIGH,
    ST_LOW,
    ST_STOP_LOW,
    ST_STOP_HIGH,
    ST_STOP_REL
  } unstick_state_e;
endpackage

// File: rtl/unstick_sync.sv
module unstick_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/unstick_phase_timer.sv
module unstick_phase_timer #(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              en_i,
  input  logic [HALF_W-1:0] limit_i,
  output logic              done_o
);
  logic [HALF_W-1:0] cnt_q;
  logic [HALF_W-1:0] last;

  // a zero half period behaves as one cycle
  assign last   = (limit_i == '0) ? '0 : limit_i - HALF_W'(1);
  assign done_o = en_i && (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clear_i || done_o) cnt_q <= '0;
    else if (en_i)              cnt_q <= cnt_q + HALF_W'(1);
  end

  // a phase never counts past its half period
  assert_phase_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> cnt_q <= last);
endmodule

// File: rtl/unstick_watchdog.sv
module unstick_watchdog #(
  parameter int LIMIT = 10_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expire_o
);
  localparam int WD_W = $clog2(LIMIT + 1);

  logic [WD_W-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == WD_W'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (!run_i)    cnt_q <= '0;
    else if (!expire_o) cnt_q <= cnt_q + WD_W'(1);
  end

  assert_wd_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> cnt_q <= WD_W'(LIMIT - 1));
endmodule

// File: rtl/unstick_sequencer.sv
module unstick_sequencer
  import i2c_unstick_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [HALF_W-1:0] half_i,
  input  logic              scl_hi_i,
  input  logic              sda_hi_i,
  input  logic              phase_done_i,
  input  logic              abort_i,
  output logic              timer_en_o,
  output logic              timer_clear_o,
  output logic [HALF_W-1:0] half_o,
  output logic              scl_low_o,
  output logic              sda_low_o,
  output logic              busy_o,
  output logic [CNT_W-1:0]  left_o,
  output logic              timeout_o
);
  unstick_state_e    state_q, state_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic [HALF_W-1:0] half_q, half_d;
  logic              to_q, to_d;
  logic              scl_low_q, sda_low_q, busy_q;

  always_comb begin
    state_d = state_q;
    left_d  = left_q;
    half_d  = half_q;
    to_d    = to_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_LEAD;
        left_d  = count_i;
        half_d  = half_i;
        to_d    = 1'b0;
      end
      ST_LEAD:      if (phase_done_i) state_d = ST_SAMPLE;
      ST_SAMPLE:    state_d = (sda_hi_i || left_q == '0) ? ST_STOP_LOW : ST_HIGH;
      ST_HIGH:      if (phase_done_i) state_d = ST_LOW;
      ST_LOW: if (phase_done_i) begin
        state_d = ST_SAMPLE;
        left_d  = left_q - CNT_W'(1);
      end
      ST_STOP_LOW:  if (phase_done_i) state_d = ST_STOP_HIGH;
      ST_STOP_HIGH: if (phase_done_i) state_d = ST_STOP_REL;
      ST_STOP_REL:  if (phase_done_i) state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
    if (abort_i && state_q != ST_IDLE) begin
      state_d = ST_IDLE;
      left_d  = '0;
      to_d    = 1'b1;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_LEAD, ST_LOW, ST_STOP_LOW, ST_STOP_REL: timer_en_o = 1'b1;
      ST_HIGH, ST_STOP_HIGH:                     timer_en_o = scl_hi_i;
      default:                                   timer_en_o = 1'b0;
    endcase
    timer_clear_o = (state_q == ST_IDLE) || (state_q == ST_SAMPLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      left_q    <= '0;
      half_q    <= '0;
      to_q      <= 1'b0;
      scl_low_q <= 1'b0;
      sda_low_q <= 1'b0;
      busy_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      left_q    <= left_d;
      half_q    <= half_d;
      to_q      <= to_d;
      scl_low_q <= (state_d == ST_LEAD) || (state_d == ST_SAMPLE) ||
                   (state_d == ST_LOW)  || (state_d == ST_STOP_LOW);
      sda_low_q <= (state_d == ST_STOP_LOW) || (state_d == ST_STOP_HIGH);
      busy_q    <= (state_d != ST_IDLE);
    end
  end

  assign half_o    = half_q;
  assign scl_low_o = scl_low_q;
  assign sda_low_o = sda_low_q;
  assign busy_o    = busy_q;
  assign left_o    = left_q;
  assign timeout_o = to_q;

  assert_sda_release_scl_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_low_q) |-> !scl_low_q);
  assert_sda_drive_scl_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_low_q) |-> scl_low_q);
  assert_left_monotonic_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && $past(busy_q) |-> left_q <= $past(left_q));
  assert_high_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_HIGH && !scl_hi_i && !abort_i |=> state_q == ST_HIGH);
  assert_abort_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i && state_q != ST_IDLE |=> !busy_q && to_q && left_q == '0 && !scl_low_q && !sda_low_q);
  assert_start_clears_timeout_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !to_q);
endmodule

// File: rtl/i2c_bus_unstick.sv
module i2c_bus_unstick #(
  parameter int CNT_W          = 4,
  parameter int HALF_W         = 16,
  parameter int SYNC_STAGES    = 2,
  parameter int TIMEOUT_CYCLES = 10_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  pulse_count_i,
  input  logic [HALF_W-1:0] half_cycles_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_drive_low_o,
  output logic              sda_drive_low_o,
  output logic              busy_o,
  output logic              timeout_o,
  output logic [CNT_W-1:0]  pulses_left_o
);
  localparam int N_PINS = 2;

  logic [N_PINS-1:0] pin_raw, pin_hi;
  logic              timer_en, timer_clear, phase_done, abort;
  logic [HALF_W-1:0] half_q;

  assign pin_raw = {sda_i, scl_i};

  for (genvar g = 0; g < N_PINS; g++) begin : g_sync
    unstick_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (pin_raw[g]),
      .q_o  (pin_hi[g])
    );
  end

  unstick_phase_timer #(.HALF_W(HALF_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear_i(timer_clear),
    .en_i   (timer_en),
    .limit_i(half_q),
    .done_o (phase_done)
  );

  unstick_watchdog #(.LIMIT(TIMEOUT_CYCLES)) u_wd (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (busy_o),
    .expire_o(abort)
  );

  unstick_sequencer #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .count_i      (pulse_count_i),
    .half_i       (half_cycles_i),
    .scl_hi_i     (pin_hi[0]),
    .sda_hi_i     (pin_hi[1]),
    .phase_done_i (phase_done),
    .abort_i      (abort),
    .timer_en_o   (timer_en),
    .timer_clear_o(timer_clear),
    .half_o       (half_q),
    .scl_low_o    (scl_drive_low_o),
    .sda_low_o    (sda_drive_low_o),
    .busy_o       (busy_o),
    .left_o       (pulses_left_o),
    .timeout_o    (timeout_o)
  );

  // lines are never held by an idle block
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !scl_drive_low_o && !sda_drive_low_o);
endmodule

// File: tb/tb_i2c_bus_unstick.sv
`timescale 1ns/1ps
module tb_i2c_bus_unstick;
  localparam int CNT_W  = 4;
  localparam int HALF_W = 8;
  localparam int TO     = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CNT_W-1:0]  cnt_cfg = '0;
  logic [HALF_W-1:0] half_cfg = 8'd2;
  logic scl_stuck = 1'b0;
  int   hold = 0;
  int   tgt_rises = 0;
  int   n_cmp = 0;
  int   n_bad = 0;

  logic scl_low, sda_low, busy, tmo;
  logic [CNT_W-1:0] left;
  logic scl_pin, sda_pin, tgt_low;

  assign scl_pin = !scl_low && !scl_stuck;
  assign tgt_low = (hold != 0) && ((tgt_rises < hold) || (tgt_rises == hold && scl_pin));
  assign sda_pin = !sda_low && !tgt_low;

  always #2.5 clk = ~clk;
  always @(posedge scl_pin) tgt_rises++;

  i2c_bus_unstick #(.CNT_W(CNT_W), .HALF_W(HALF_W), .TIMEOUT_CYCLES(TO)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .pulse_count_i(cnt_cfg),
    .half_cycles_i(half_cfg), .scl_i(scl_pin), .sda_i(sda_pin),
    .scl_drive_low_o(scl_low), .sda_drive_low_o(sda_low), .busy_o(busy),
    .timeout_o(tmo), .pulses_left_o(left)
  );

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic run(input int h, input int c, input int hd, input bit poke, input bit stuck);
    int dur, rises, stops, starts, first_rel, p;
    bit ps, pd;
    @(negedge clk);
    half_cfg  = HALF_W'(h);
    cnt_cfg   = CNT_W'(c);
    hold      = hd;
    scl_stuck = stuck;
    tgt_rises = 0;
    start     = 1'b1;
    ps = scl_pin; pd = sda_pin;
    @(negedge clk);
    start = 1'b0;
    check("R2", "busy after start", busy, 1);
    check("R2", "timeout cleared at start", tmo, 0);
    check("R3", "lead scl driven", scl_low, 1);
    check("R3", "lead sda released", sda_low, 0);
    dur = 0; rises = 0; stops = 0; starts = 0; first_rel = -1;
    while (busy && dur < 2000) begin
      if (scl_pin && !ps) begin
        rises++;
        if (first_rel < 0) first_rel = dur;
      end
      if (ps && scl_pin && !pd && sda_pin) stops++;
      if (ps && scl_pin && pd && !sda_pin) starts++;
      if (poke && dur == 5) begin
        start = 1'b1; cnt_cfg = 4'd15; half_cfg = 8'd7;
      end else start = 1'b0;
      ps = scl_pin; pd = sda_pin;
      dur++;
      @(negedge clk);
    end
    start = 1'b0;
    check("R1", "scl released when idle", scl_low, 0);
    check("R1", "sda released when idle", sda_low, 0);
    if (stuck) begin
      check("R8", "abort duration", dur, TO);
      check("R8", "timeout flag", tmo, 1);
      check("R8", "pulses zeroed", left, 0);
      check("R8", "no pulses with scl stuck", rises, 0);
    end else begin
      p = (hd < c) ? hd : c;
      check("R7", "run duration", dur, 4*h + 3 + p*(2*h + 3));
      check("R7", "pulses left", left, c - p);
      check("R7", "no timeout", tmo, 0);
      check("R5", "scl rises (pulses + stop)", rises, p + 1);
      check("R6", "no false start", starts, 0);
      if (hd <= c) check("R6", "one stop seen", stops, 1);
      check("R3", "first scl release index", first_rel, (p > 0) ? h + 1 : 2*h + 1);
      if (poke) check("R9", "poked run unchanged", dur, 4*h + 3 + p*(2*h + 3));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: bench did not finish, actual 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset busy", busy, 0);
    check("R1", "reset scl drive", scl_low, 0);
    check("R1", "reset sda drive", sda_low, 0);
    check("R1", "reset timeout", tmo, 0);
    check("R1", "reset pulses left", left, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // near-exhaustive sweep at the smallest half period
    for (int c = 0; c <= 12; c++)
      for (int hd = 0; hd <= 13; hd++)
        run(2, c, hd, 1'b0, 1'b0);
    run(2, 15, 15, 1'b0, 1'b0);
    run(2, 15, 20, 1'b0, 1'b0);
    // other half periods
    for (int hi = 0; hi < 2; hi++)
      for (int ci = 0; ci < 3; ci++)
        for (int hd = 0; hd <= 10; hd++)
          run((hi == 0) ? 3 : 5, (ci == 0) ? 0 : (ci == 1) ? 1 : 9, hd, 1'b0, 1'b0);
    // R9: start and config pokes while busy
    run(3, 4, 2, 1'b1, 1'b0);
    run(2, 9, 20, 1'b1, 1'b0);
    // R8: scl held low by a target
    run(2, 9, 3, 1'b0, 1'b1);
    @(negedge clk);
    scl_stuck = 1'b0;
    repeat (4) @(negedge clk);
    check("R8", "timeout holds while idle", tmo, 1);
    check("R8", "still idle after abort", busy, 0);
    run(2, 9, 2, 1'b0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule